// File: doc/BRIEF.md
# Cross-Domain Single-Word Handshake Link

This block carries one data word at a time between two clock domains that share no timing relationship. A sender and a receiver are joined by a data bus and three control wires: a request from the receiver (READY), a data-present flag from the sender (VALID), and a capture acknowledge from the receiver (ACCEPT). Each side passes the control wires it receives through a synchroniser chain in its own clock domain. It then acts on the rising transitions it detects in them. It does not act on plain levels.

The receiver opens each transfer by raising READY while its local request input is high. The sender holds a word that its local side loaded. When it sees READY rise, it places the word on the bus and raises VALID one cycle later. When the receiver sees VALID rise, it captures the bus. In the same cycle it drops READY, raises ACCEPT and pulses a one-cycle strobe together with the captured word. When the sender sees ACCEPT rise, it drops VALID and becomes free again. When the receiver sees VALID low, it drops ACCEPT, and the link is idle once more. The receiver raises READY for the next word only after that point.

Top module: `xdom_word_link`

## Requirements
- R1: While either reset is low, and after reset with no activity, READY, VALID and ACCEPT are low, `snd_busy` is low and `rcv_strobe` is low.
- R2: The receiver raises READY only from idle with `rcv_req` high. While `rcv_req` stays low, no transfer completes and a loaded word waits at the sender.
- R3: The sender raises VALID only after READY has risen. The bus value stays unchanged for as long as VALID is high.
- R4: On a detected VALID rise, the receiver lowers READY and raises ACCEPT in the same cycle, and pulses the strobe in that cycle.
- R5: `rcv_strobe` is high for exactly one receive clock cycle per transfer, and `rcv_word` then carries the captured word.
- R6: The sender lowers VALID and clears `snd_busy` after seeing ACCEPT rise. The receiver lowers ACCEPT after seeing VALID low. READY rises again only while VALID and ACCEPT are both low.
- R7: `snd_load` is taken only while `snd_busy` is low, and `snd_busy` is high in the cycle after the load. A load pulse while busy has no effect on any delivered word.
- R8: Every loaded word is delivered exactly once, in load order and bit-exact, with the two clocks at unrelated frequency and phase.
- R9: A READY rise that arrives while the sender holds no word is remembered. The word loaded later is then sent without a new READY edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| snd_clk | input | 1 | Sender clock |
| snd_rst_n | input | 1 | Sender synchronous reset, active low |
| snd_load | input | 1 | Load `snd_word` for sending (taken when not busy) |
| snd_word | input | WIDTH | Word to send |
| snd_busy | output | 1 | Sender holds a word that is not yet acknowledged |
| rcv_clk | input | 1 | Receiver clock |
| rcv_rst_n | input | 1 | Receiver synchronous reset, active low |
| rcv_req | input | 1 | Receiver wants a word |
| rcv_strobe | output | 1 | One-cycle pulse: a word was captured |
| rcv_word | output | WIDTH | Captured word |
| link_ready | output | 1 | READY wire, receiver to sender |
| link_valid | output | 1 | VALID wire, sender to receiver |
| link_accept | output | 1 | ACCEPT wire, receiver to sender |
| link_data | output | WIDTH | Data bus, sender to receiver |

## Verification
A lost edge in either state machine freezes the link. `snd_busy` then stays high, or the strobe count stops, within a few dozen cycles of the stuck transfer. A corrupted or stale word register shows up at the next strobe as a mismatch against the arithmetic word sequence. A wrong ordering of the control wires shows up at the strobe cycle itself: ACCEPT is not yet high, READY is still high, or VALID is already low. A duplicated or missing transfer appears as a wrong strobe count after the stream has settled.

// File: rtl/xlink_pkg.sv
// Shared state encodings for the cross-domain word link.
package xlink_pkg;
    typedef enum logic [1:0] {
        SND_EMPTY,
        SND_LOADED,
        SND_SETUP,
        SND_WAIT
    } snd_state_t;

    typedef enum logic [1:0] {
        RCV_IDLE,
        RCV_ASK,
        RCV_ACK
    } rcv_state_t;
endpackage

// File: rtl/xlink_sync.sv
// Synchroniser chain with a rising-transition detector.
// Assumes: async_in may change at any time relative to clk.
// The chain is STAGES deep (at least 2).
module xlink_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic level,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              last;

    // Shift the asynchronous input through the chain and keep the previous output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
            last  <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], async_in};
            last  <= chain[STAGES-1];
        end
    end

    assign level = chain[STAGES-1];
    assign rise  = chain[STAGES-1] & ~last;
endmodule

// File: rtl/xlink_sender.sv
// Sending side of the link. It holds one word loaded by the local side.
// On a READY rise it drives the word on the bus and raises VALID a cycle
// later. It drops VALID when ACCEPT rises.
// Assumes: ready_in and accept_in come from the other clock domain.
module xlink_sender
    import xlink_pkg::*;
#(
    parameter int WIDTH       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] word_in,
    output logic             busy,
    input  logic             ready_in,
    input  logic             accept_in,
    output logic             valid_out,
    output logic [WIDTH-1:0] data_out
);
    snd_state_t       state;
    logic [WIDTH-1:0] hold;
    logic             pend;
    logic             ready_lvl, ready_rise, accept_lvl, accept_rise;

    xlink_sync #(.STAGES(SYNC_STAGES)) u_sync_ready (
        .clk(clk), .rst_n(rst_n), .async_in(ready_in),
        .level(ready_lvl), .rise(ready_rise)
    );

    xlink_sync #(.STAGES(SYNC_STAGES)) u_sync_accept (
        .clk(clk), .rst_n(rst_n), .async_in(accept_in),
        .level(accept_lvl), .rise(accept_rise)
    );

    // Sender state machine: load, wait for a request, present, wait for acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= SND_EMPTY;
            hold      <= '0;
            data_out  <= '0;
            valid_out <= 1'b0;
            pend      <= 1'b0;
        end else begin
            if (ready_rise) begin
                pend <= 1'b1;
            end else if (!ready_lvl) begin
                pend <= 1'b0;
            end
            case (state)
                SND_EMPTY: begin
                    if (load) begin
                        hold  <= word_in;
                        state <= SND_LOADED;
                    end
                end
                SND_LOADED: begin
                    if ((pend || ready_rise) && !accept_lvl) begin
                        data_out <= hold;
                        pend     <= 1'b0;
                        state    <= SND_SETUP;
                    end
                end
                SND_SETUP: begin
                    valid_out <= 1'b1;
                    state     <= SND_WAIT;
                end
                SND_WAIT: begin
                    if (accept_rise) begin
                        valid_out <= 1'b0;
                        state     <= SND_EMPTY;
                    end
                end
                default: state <= SND_EMPTY;
            endcase
        end
    end

    assign busy = (state != SND_EMPTY);
endmodule

// File: rtl/xlink_receiver.sv
// Receiving side of the link. It raises READY when asked, captures the bus
// on a VALID rise, then swaps READY for ACCEPT. It drops ACCEPT once it
// sees VALID low.
// Assumes: the bus is stable before VALID rises; valid_in is asynchronous.
module xlink_receiver
    import xlink_pkg::*;
#(
    parameter int WIDTH       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             valid_in,
    input  logic [WIDTH-1:0] data_in,
    output logic             ready_out,
    output logic             accept_out,
    output logic             strobe,
    output logic [WIDTH-1:0] word_out
);
    rcv_state_t state;
    logic       valid_lvl, valid_rise;

    xlink_sync #(.STAGES(SYNC_STAGES)) u_sync_valid (
        .clk(clk), .rst_n(rst_n), .async_in(valid_in),
        .level(valid_lvl), .rise(valid_rise)
    );

    // Receiver state machine: request, capture and acknowledge, return to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= RCV_IDLE;
            ready_out  <= 1'b0;
            accept_out <= 1'b0;
            strobe     <= 1'b0;
            word_out   <= '0;
        end else begin
            strobe <= 1'b0;
            case (state)
                RCV_IDLE: begin
                    if (req) begin
                        ready_out <= 1'b1;
                        state     <= RCV_ASK;
                    end
                end
                RCV_ASK: begin
                    if (valid_rise) begin
                        word_out   <= data_in;
                        strobe     <= 1'b1;
                        ready_out  <= 1'b0;
                        accept_out <= 1'b1;
                        state      <= RCV_ACK;
                    end
                end
                RCV_ACK: begin
                    if (!valid_lvl) begin
                        accept_out <= 1'b0;
                        state      <= RCV_IDLE;
                    end
                end
                default: state <= RCV_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/xdom_word_link.sv
// Top of the cross-domain word link: one sender and one receiver joined by
// the data bus and the READY / VALID / ACCEPT wires, which are also brought out.
// Assumes: snd_clk and rcv_clk are unrelated; each reset is synchronous to its clock.
module xdom_word_link #(
    parameter int WIDTH       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             snd_clk,
    input  logic             snd_rst_n,
    input  logic             snd_load,
    input  logic [WIDTH-1:0] snd_word,
    output logic             snd_busy,
    input  logic             rcv_clk,
    input  logic             rcv_rst_n,
    input  logic             rcv_req,
    output logic             rcv_strobe,
    output logic [WIDTH-1:0] rcv_word,
    output logic             link_ready,
    output logic             link_valid,
    output logic             link_accept,
    output logic [WIDTH-1:0] link_data
);
    xlink_sender #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) u_sender (
        .clk(snd_clk), .rst_n(snd_rst_n),
        .load(snd_load), .word_in(snd_word), .busy(snd_busy),
        .ready_in(link_ready), .accept_in(link_accept),
        .valid_out(link_valid), .data_out(link_data)
    );

    xlink_receiver #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) u_receiver (
        .clk(rcv_clk), .rst_n(rcv_rst_n), .req(rcv_req),
        .valid_in(link_valid), .data_in(link_data),
        .ready_out(link_ready), .accept_out(link_accept),
        .strobe(rcv_strobe), .word_out(rcv_word)
    );
endmodule

// File: rtl/xdom_word_link_chk.sv
// Protocol checker for the word link, bound to the top module.
// Assumes: both resets are released close together.
module xdom_word_link_chk #(
    parameter int WIDTH = 16
) (
    input logic             snd_clk,
    input logic             snd_rst_n,
    input logic             rcv_clk,
    input logic             rcv_rst_n,
    input logic             snd_busy,
    input logic             rcv_strobe,
    input logic             link_ready,
    input logic             link_valid,
    input logic             link_accept,
    input logic [WIDTH-1:0] link_data
);
    assert_data_hold_R3: assert property (@(posedge snd_clk) disable iff (!snd_rst_n || !rcv_rst_n)
        (link_valid && $past(link_valid)) |-> $stable(link_data));

    assert_valid_after_ready_R3: assert property (@(posedge snd_clk) disable iff (!snd_rst_n || !rcv_rst_n)
        $rose(link_valid) |-> link_ready);

    assert_valid_needs_busy_R6: assert property (@(posedge snd_clk) disable iff (!snd_rst_n || !rcv_rst_n)
        link_valid |-> snd_busy);

    assert_ack_swap_R4: assert property (@(posedge rcv_clk) disable iff (!snd_rst_n || !rcv_rst_n)
        $rose(link_accept) |-> $fell(link_ready));

    assert_accept_excl_R4: assert property (@(posedge rcv_clk) disable iff (!snd_rst_n || !rcv_rst_n)
        link_accept |-> !link_ready);

    assert_strobe_with_ack_R4: assert property (@(posedge rcv_clk) disable iff (!snd_rst_n || !rcv_rst_n)
        rcv_strobe |-> $rose(link_accept));

    assert_strobe_single_R5: assert property (@(posedge rcv_clk) disable iff (!snd_rst_n || !rcv_rst_n)
        rcv_strobe |=> !rcv_strobe);

    assert_ready_from_idle_R6: assert property (@(posedge rcv_clk) disable iff (!snd_rst_n || !rcv_rst_n)
        $rose(link_ready) |-> (!link_valid && !link_accept));
endmodule

bind xdom_word_link xdom_word_link_chk #(.WIDTH(WIDTH)) u_chk (
    .snd_clk(snd_clk), .snd_rst_n(snd_rst_n),
    .rcv_clk(rcv_clk), .rcv_rst_n(rcv_rst_n),
    .snd_busy(snd_busy), .rcv_strobe(rcv_strobe),
    .link_ready(link_ready), .link_valid(link_valid),
    .link_accept(link_accept), .link_data(link_data)
);

// File: tb/tb_xdom_word_link.sv
`timescale 1ns/1ps
module tb_xdom_word_link;
    localparam int W = 16;
    localparam int N = 48;

    logic         snd_clk = 1'b0, rcv_clk = 1'b0;
    logic         snd_rst_n = 1'b0, rcv_rst_n = 1'b0;
    logic         snd_load = 1'b0, rcv_req = 1'b0;
    logic [W-1:0] snd_word = '0;
    logic         snd_busy, rcv_strobe, link_ready, link_valid, link_accept;
    logic [W-1:0] rcv_word, link_data;

    int checks = 0, bads = 0, rx_count = 0;
    bit prev_strobe = 1'b0;

    xdom_word_link #(.WIDTH(W), .SYNC_STAGES(2)) dut (
        .snd_clk(snd_clk), .snd_rst_n(snd_rst_n), .snd_load(snd_load),
        .snd_word(snd_word), .snd_busy(snd_busy),
        .rcv_clk(rcv_clk), .rcv_rst_n(rcv_rst_n), .rcv_req(rcv_req),
        .rcv_strobe(rcv_strobe), .rcv_word(rcv_word),
        .link_ready(link_ready), .link_valid(link_valid),
        .link_accept(link_accept), .link_data(link_data)
    );

    always #2 snd_clk = ~snd_clk;              // 250 MHz sender clock
    initial begin
        #1.3;
        forever #3.35 rcv_clk = ~rcv_clk;      // unrelated receiver clock
    end

    function automatic logic [W-1:0] exp_word(input int k);
        return W'((k * 40503 + 4660) ^ (k << 7));
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            bads++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [W-1:0] w);
        @(negedge snd_clk);
        while (snd_busy) @(negedge snd_clk);
        snd_load = 1'b1;
        snd_word = w;
        @(negedge snd_clk);
        snd_load = 1'b0;
        chk(snd_busy == 1'b1, "R7 busy after load", 32'(snd_busy), 1);
    endtask

    // Receive-side monitor: word order, strobe width and wire state at capture.
    always @(negedge rcv_clk) begin
        if (rcv_rst_n) begin
            if (rcv_strobe) begin
                chk(!prev_strobe, "R5 strobe width", 32'(prev_strobe), 0);
                chk(rcv_word == exp_word(rx_count), "R8 word", 32'(rcv_word), 32'(exp_word(rx_count)));
                chk(link_accept && !link_ready, "R4 accept/ready", {link_accept, link_ready}, 2'b10);
                chk(link_valid, "R3 valid held at capture", 32'(link_valid), 1);
                rx_count++;
            end
            prev_strobe = rcv_strobe;
        end
    end

    initial begin
        repeat (150000) @(posedge snd_clk);
        checks++;
        bads++;
        $display("FAIL watchdog actual=%0d expected=%0d", rx_count, N);
        $display("  test done: total=%0d bad=%0d", checks, bads);
        $finish;
    end

    initial begin
        repeat (5) @(negedge snd_clk);
        chk({link_ready, link_valid, link_accept, snd_busy, rcv_strobe} == 5'b0, "R1 in reset",
            {link_ready, link_valid, link_accept, snd_busy, rcv_strobe}, 0);
        snd_rst_n = 1'b1;
        rcv_rst_n = 1'b1;
        repeat (10) @(negedge snd_clk);
        chk({link_ready, link_valid, link_accept, snd_busy, rcv_strobe} == 5'b0, "R1 after reset",
            {link_ready, link_valid, link_accept, snd_busy, rcv_strobe}, 0);

        // No request: a loaded word must wait; a load while busy is dropped.
        send(exp_word(0));
        @(negedge snd_clk);
        snd_load = 1'b1;
        snd_word = 16'hDEAD;
        @(negedge snd_clk);
        snd_load = 1'b0;
        repeat (200) @(negedge snd_clk);
        chk(rx_count == 0, "R2 no transfer without request", rx_count, 0);
        chk(link_ready == 1'b0, "R2 ready low", 32'(link_ready), 0);
        chk(link_valid == 1'b0, "R3 valid waits for ready", 32'(link_valid), 0);
        chk(snd_busy == 1'b1, "R7 word held", 32'(snd_busy), 1);

        rcv_req = 1'b1;
        wait (rx_count == 1);

        for (int k = 1; k < N; k++) begin
            if (k == N / 2) begin
                repeat (60) @(negedge snd_clk);
                chk(link_ready && !snd_busy, "R9 request pending before load",
                    {link_ready, snd_busy}, 2'b10);
            end else begin
                repeat (k % 5) @(negedge snd_clk);
            end
            send(exp_word(k));
        end
        wait (rx_count == N);
        repeat (100) @(negedge snd_clk);
        chk(rx_count == N, "R8 delivered once", rx_count, N);
        chk(snd_busy == 1'b0, "R6 busy cleared", 32'(snd_busy), 0);
        chk(!link_valid && !link_accept, "R6 idle wires", {link_valid, link_accept}, 0);
        chk(link_ready == 1'b1, "R6 next request raised", 32'(link_ready), 1);

        $display("  test done: total=%0d bad=%0d", checks, bads);
        $finish;
    end
endmodule